// File: doc/BRIEF.md
# Serial-Search Spreading Code Acquisition

This block gives a direct-sequence BPSK receiver its coarse code timing. It takes one signed baseband sample per clock, so the clock runs at the chip rate. It drives a local pseudo-noise chip from a 7-bit linear feedback shift register. For each code-phase hypothesis it correlates the input against the local chip over one code period of 127 chips. One code period is one data symbol. It then squares the correlation sum and compares the result with a programmable threshold. A hypothesis that passes raises `lock_o`, which also serves as the enable for the downstream tracking loop. Otherwise the local code is slipped by one chip and the next hypothesis is tried.

After lock the local code runs freely at one chip per clock and the winning phase index is held. The tracker can pull the block back into search by pulsing a loss-of-lock input. The block also returns to search on its own after a programmable number of locked code periods. On a return to search, the held phase is tested first. A sweep over all 127 hypotheses without a detection wraps round to phase 0 and counts the sweep.

Top module: `acq_serial_search`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release: `lock_o`=0, `phase_o`=0, `sweep_cnt_o`=0 and `chip_o`=1. The register is seeded with all ones and `chip_o` is its MSB.
- R2: The local code register advances once per clock as next = {s[5:0], s[6]^s[5]}, starting from 7'h7F. `chip_o` is s[6] and the register is never zero.
- R3: Dwells are 127 clocks long and aligned to reset release. Over a dwell the block sums sample×(+1 if `chip_o`=1, else −1). The hypothesis is accepted only if the squared sum is strictly greater than `threshold_i`.
- R4: A rejected hypothesis adds one extra register advance in the last cycle of its dwell. `phase_o` increments by one from the next cycle.
- R5: An accepted hypothesis sets `lock_o` in the cycle after the dwell ends. While locked, `phase_o` stays at the winning phase and no extra advances occur.
- R6: Rejecting phase 126 makes `phase_o` wrap to 0 and increments `sweep_cnt_o` by one.
- R7: A `loss_i` pulse while locked clears `lock_o` in the next cycle. The rest of the current code period is discarded without a decision. Search resumes at the next period boundary, testing the held phase first.
- R8: `loss_i` while searching has no effect on `phase_o`, `lock_o` or the timing of the search.
- R9: With `reacq_periods_i`=N≠0, lock is held for exactly N code periods (N×127 clocks). Search then resumes at the held phase. With N=0 lock is never dropped by the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 8 | Signed baseband sample, one per chip |
| threshold_i | input | 32 | Energy threshold, unsigned |
| reacq_periods_i | input | 16 | Locked code periods before a forced search, 0 disables |
| loss_i | input | 1 | Loss-of-lock pulse from the tracker |
| chip_o | output | 1 | Local pseudo-noise chip |
| lock_o | output | 1 | Coarse lock, also the enable for the tracking loop |
| phase_o | output | 7 | Current or winning phase hypothesis |
| sweep_cnt_o | output | 8 | Number of completed sweeps without detection |

## Verification
The bench feeds the code back at a chosen chip offset, with random BPSK data signs and noise, and checks that lock appears exactly at the end of the matching dwell. A slip applied at the wrong edge would move lock by a whole dwell or lock on the wrong phase. An energy exactly equal to the threshold must not lock, which catches a non-strict compare. A silent input runs a full sweep to show the wrap to phase 0 and the sweep count step.

Loss of lock is applied in the middle of a period while the received offset moves. This shows that the partial dwell is discarded and that search restarts at the held phase. A design that decided on the partial sum, or stepped the phase at the skipped boundary, would lock one dwell early or late. The timer test measures the exact length of the locked interval and the relock time, and a zero interval must hold lock indefinitely.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } acq_state_e;
endpackage

// File: rtl/acq_pn_gen.sv
module acq_pn_gen #(
  parameter int          W    = 7,
  parameter logic [W-1:0] TAPS = 7'b1100000,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic chip_o
);
  logic [W-1:0] s_q;

  function automatic logic [W-1:0] adv(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (step_i) s_q <= adv(adv(s_q));  // slip one chip
    else             s_q <= adv(s_q);
  end

  assign chip_o = s_q[W-1];

  p_state_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0);
endmodule

// File: rtl/acq_correlator.sv
module acq_correlator #(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 7,
  parameter int ACC_W    = 16,
  parameter int ENERGY_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       chip_i,
  input  logic [ENERGY_W-1:0]        threshold_i,
  output logic                       last_o,
  output logic                       hit_o
);
  localparam int LEN = (1 << CNT_W) - 1;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q, ext, term, sum;
  logic signed [ENERGY_W-1:0] sq;
  logic [ENERGY_W-1:0]     energy;

  assign last_o = (cnt_q == CNT_W'(LEN - 1));
  assign ext    = ACC_W'(sample_i);
  assign term   = chip_i ? ext : -ext;
  assign sum    = acc_q + term;
  assign sq     = ENERGY_W'(sum) * ENERGY_W'(sum);
  assign energy = unsigned'(sq);
  assign hit_o  = energy > threshold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (last_o) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      acc_q <= sum;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q < CNT_W'(LEN));
  p_energy_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) !sq[ENERGY_W-1]);
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int REACQ_W = 16,
  parameter int SWEEP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               last_i,
  input  logic               hit_i,
  input  logic               loss_i,
  input  logic [REACQ_W-1:0] reacq_i,
  output logic               step_o,
  output logic               lock_o,
  output logic [CNT_W-1:0]   phase_o,
  output logic [SWEEP_W-1:0] sweep_o
);
  localparam int LEN = (1 << CNT_W) - 1;

  acq_state_e         state_q;
  logic               skip_q;
  logic [CNT_W-1:0]   phase_q;
  logic [SWEEP_W-1:0] sweep_q;
  logic [REACQ_W-1:0] rcnt_q;
  logic               phase_end, reacq_due;

  assign phase_end = (phase_q == CNT_W'(LEN - 1));
  assign reacq_due = (reacq_i != '0) && (rcnt_q == reacq_i - REACQ_W'(1));
  assign step_o    = (state_q == ST_SEARCH) && last_i && !skip_q && !hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      skip_q  <= 1'b0;
      phase_q <= '0;
      sweep_q <= '0;
      rcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_SEARCH: if (last_i) begin
          if (skip_q) skip_q <= 1'b0;  // partial dwell after loss
          else if (hit_i) begin
            state_q <= ST_LOCKED;
            rcnt_q  <= '0;
          end else begin
            phase_q <= phase_end ? '0 : phase_q + CNT_W'(1);
            if (phase_end) sweep_q <= sweep_q + SWEEP_W'(1);
          end
        end
        ST_LOCKED: begin
          if (loss_i) begin
            state_q <= ST_SEARCH;
            skip_q  <= !last_i;
          end else if (last_i) begin
            if (reacq_due) begin
              state_q <= ST_SEARCH;
              rcnt_q  <= '0;
            end else begin
              rcnt_q <= rcnt_q + REACQ_W'(1);
            end
          end
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  assign lock_o  = (state_q == ST_LOCKED);
  assign phase_o = phase_q;
  assign sweep_o = sweep_q;

  p_phase_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) phase_q < CNT_W'(LEN));
  p_wrap_sweep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && phase_end) |=> (phase_q == '0) && (sweep_q == $past(sweep_q) + SWEEP_W'(1)));
  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED) |=> $stable(phase_q) && $stable(sweep_q));
  p_hit_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && last_i && !skip_q && hit_i) |=> lock_o);
  p_loss_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && loss_i) |=> !lock_o);
  p_search_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && loss_i && !last_i) |=> !lock_o && $stable(phase_q));
  p_no_step_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !lock_o);
endmodule

// File: rtl/acq_serial_search.sv
module acq_serial_search #(
  parameter int SAMPLE_W = 8,
  parameter int LFSR_W   = 7,
  parameter int REACQ_W  = 16,
  parameter int SWEEP_W  = 8,
  parameter int ACC_W    = SAMPLE_W + LFSR_W + 1,
  parameter int ENERGY_W = 2 * ACC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [ENERGY_W-1:0]        threshold_i,
  input  logic [REACQ_W-1:0]         reacq_periods_i,
  input  logic                       loss_i,
  output logic                       chip_o,
  output logic                       lock_o,
  output logic [LFSR_W-1:0]          phase_o,
  output logic [SWEEP_W-1:0]         sweep_cnt_o
);
  logic step, last, hit, chip;

  acq_pn_gen #(.W(LFSR_W)) u_pn (
    .clk_i (clk_i), .rst_ni(rst_ni), .step_i(step), .chip_o(chip)
  );

  acq_correlator #(
    .SAMPLE_W(SAMPLE_W), .CNT_W(LFSR_W), .ACC_W(ACC_W), .ENERGY_W(ENERGY_W)
  ) u_corr (
    .clk_i (clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .chip_i(chip),
    .threshold_i(threshold_i), .last_o(last), .hit_o(hit)
  );

  acq_ctrl #(.CNT_W(LFSR_W), .REACQ_W(REACQ_W), .SWEEP_W(SWEEP_W)) u_ctrl (
    .clk_i (clk_i), .rst_ni(rst_ni), .last_i(last), .hit_i(hit), .loss_i(loss_i),
    .reacq_i(reacq_periods_i), .step_o(step), .lock_o(lock_o),
    .phase_o(phase_o), .sweep_o(sweep_cnt_o)
  );

  assign chip_o = chip;
endmodule

// File: tb/acq_serial_search_tb_top.sv
module acq_serial_search_tb_top;
  localparam int L = 127;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [7:0] sample_i = '0;
  logic [31:0]       threshold_i = '0;
  logic [15:0]       reacq_periods_i = '0;
  logic              loss_i = 1'b0;
  logic              chip_o, lock_o;
  logic [6:0]        phase_o;
  logic [7:0]        sweep_cnt_o;

  acq_serial_search dut_i (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit cseq [L];
  int t, d, amp, noise, new_d, loss_at, loss_at2, dsign, cap, chip_err;
  bit data_rand, chip_chk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  task automatic drive();
    int v, n, ex;
    if (chip_chk) begin
      ex = (t / L < cap) ? t / L : cap;
      if (chip_o !== cseq[(t + ex) % L]) chip_err++;
    end
    if (t == loss_at) d = new_d;
    loss_i = (t == loss_at) || (t == loss_at2);
    if (t % L == 0) dsign = (data_rand && $urandom_range(0, 1) == 1) ? -1 : 1;
    n = (noise > 0) ? $urandom_range(0, 2 * noise) - noise : 0;
    v = dsign * amp * (cseq[(t + d) % L] ? 1 : -1) + n;
    sample_i = 8'(v);
  endtask

  task automatic to_cycle(int c);
    while (t < c) begin
      drive();
      @(negedge clk_i);
      t++;
    end
  endtask

  task automatic start(int dd, int a, int nz, bit dr, int thr, int rq);
    rst_ni = 1'b0; loss_i = 1'b0; sample_i = '0;
    d = dd; amp = a; noise = nz; data_rand = dr; loss_at = -1; loss_at2 = -1;
    threshold_i = 32'(thr); reacq_periods_i = 16'(rq); chip_chk = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 reset lock", lock_o, 0);
    chk("R1 reset phase", phase_o, 0);
    rst_ni = 1'b1;
    t = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] s;
    void'($urandom(32'd4242));
    s = 7'h7F;
    for (int i = 0; i < L; i++) begin
      cseq[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end

    // A: offset 5, timer disabled, code sequence and slips checked
    start(5, 20, 2, 1'b1, 1000000, 0);
    chk("R1 sweep", sweep_cnt_o, 0);
    chk("R1 chip", chip_o, 1);
    chip_chk = 1'b1; cap = 5; chip_err = 0;
    to_cycle(254);  chk("R4 phase after two rejects", phase_o, 2);
    to_cycle(761);  chk("R3 no lock before dwell end", lock_o, 0);
                    chk("R4 phase 5", phase_o, 5);
    to_cycle(762);  chk("R5 lock", lock_o, 1);
                    chk("R5 winning phase", phase_o, 5);
    to_cycle(1100); chk("R2 local chip sequence", chip_err, 0);
    chip_chk = 1'b0;
    to_cycle(762 + 10 * L); chk("R9 zero interval holds lock", lock_o, 1);
                    chk("R5 phase held", phase_o, 5);

    // B: periodic reacquisition every 4 periods
    start(3, 20, 2, 1'b1, 1000000, 4);
    to_cycle(508);  chk("R5 lock B", lock_o, 1);
    to_cycle(1015); chk("R9 held N periods", lock_o, 1);
    to_cycle(1016); chk("R9 drop after N periods", lock_o, 0);
                    chk("R9 phase kept", phase_o, 3);
    to_cycle(1142); chk("R9 still searching", lock_o, 0);
    to_cycle(1143); chk("R9 relock held phase", lock_o, 1);
                    chk("R9 relock phase", phase_o, 3);

    // C: loss of lock mid period, offset moves to 30
    start(10, 20, 2, 1'b1, 1000000, 0);
    loss_at = 1691; new_d = 30; loss_at2 = 2000;
    to_cycle(1397); chk("R5 lock C", lock_o, 1);
    to_cycle(1692); chk("R7 lock drops", lock_o, 0);
                    chk("R7 phase kept", phase_o, 10);
    to_cycle(1778); chk("R7 no step at skipped boundary", phase_o, 10);
    to_cycle(1905); chk("R7 search resumes", phase_o, 11);
    to_cycle(2001); chk("R8 loss in search ignored lock", lock_o, 0);
                    chk("R8 loss in search ignored phase", phase_o, 11);
    to_cycle(4444); chk("R8 search timing", lock_o, 0);
                    chk("R7 phase before relock", phase_o, 30);
    to_cycle(4445); chk("R7 relock", lock_o, 1);
                    chk("R7 relock phase", phase_o, 30);

    // D: silence for a full sweep, then offset 2
    start(0, 0, 3, 1'b0, 1000000, 0);
    to_cycle(16128); chk("R6 last phase", phase_o, 126);
                     chk("R6 sweep before wrap", sweep_cnt_o, 0);
    to_cycle(16129); chk("R6 wrap phase", phase_o, 0);
                     chk("R6 sweep count", sweep_cnt_o, 1);
    d = 2; amp = 20;
    to_cycle(16509); chk("R3 no lock D", lock_o, 0);
    to_cycle(16510); chk("R3 lock second sweep", lock_o, 1);
                     chk("R6 phase after wrap", phase_o, 2);
                     chk("R6 sweep held", sweep_cnt_o, 1);

    // E: energy equal to threshold must not lock, one less must
    start(1, 8, 0, 1'b0, 1032256, 0);
    to_cycle(254); chk("R3 equal energy no lock", lock_o, 0);
                   chk("R3 equal energy steps", phase_o, 2);
    start(1, 8, 0, 1'b0, 1032255, 0);
    to_cycle(254); chk("R3 above threshold locks", lock_o, 1);
                   chk("R3 above threshold phase", phase_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule